// File: doc/BRIEF.md
# Bi-Quinary Decade Counter with Zero and Nine Presets

The block is a four-bit counter made of two stages that can run on their own or be linked. A modulo-two stage holds the low output bit and advances on each high-to-low transition of count input A. A modulo-five stage holds the upper three output bits and advances on each high-to-low transition of count input B. All logic runs on one system clock. The count inputs are sampled on that clock, and their falling edges are found by comparing each sample with the one before it.

A two-bit link selector chains the stages without external wiring. In decimal mode the low bit falling from 1 to 0 advances the upper stage, so pulses on A step the output through 0 to 9. In bi-quinary mode the upper stage wrapping from 4 to 0 advances the low bit, so pulses on B give a five-and-two code, and the low bit becomes a square wave at one tenth of the B pulse rate. There are two pairs of gated control inputs. When both inputs of one pair are high the output is forced to zero. When both inputs of the other pair are high the output is forced to nine, and this pair wins over the zero pair.

Top module: `bq_decade_counter`

## Requirements
- R1: While rst_n is low, and right after it is released, count reads 4'b0000.
- R2: With link_mode 0, each falling edge of cnt_a inverts count[0], and count[3:1] is left unchanged.
- R3: With link_mode 0, falling edges of cnt_b step count[3:1] through 0,1,2,3,4 and then back to 0. The field never holds a value above 4.
- R4: Rising edges of the count inputs, and inputs held at a steady level, leave count unchanged.
- R5: When zero_a and zero_b are both high and the nine pair is not both high, count becomes 4'b0000 on the next clock and stays there while the pair is held.
- R6: When nine_a and nine_b are both high, count becomes 4'b1001 on the next clock, whatever the zero pair is doing.
- R7: Counting goes on when only one input of a control pair is high. Falling edges that arrive while a pair is fully asserted are dropped and are not counted after release.
- R8: With link_mode 1, falling edges of cnt_a step count through binary 0 to 9 and then back to 0. cnt_b has no effect.
- R9: With link_mode 2, falling edges of cnt_b step count[3:1] through 0 to 4, and each wrap from 4 to 0 inverts count[0]. cnt_a has no effect.
- R10: With link_mode 2, starting from zero, count[0] is high after exactly five of every ten cnt_b pulses (pulses 5 to 9).
- R11: link_mode 3 behaves exactly like link_mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and releases synchronously |
| cnt_a | input | 1 | Count input of the modulo-two stage |
| cnt_b | input | 1 | Count input of the modulo-five stage |
| zero_a | input | 1 | Zero-force pair, input one |
| zero_b | input | 1 | Zero-force pair, input two |
| nine_a | input | 1 | Nine-force pair, input one |
| nine_b | input | 1 | Nine-force pair, input two |
| link_mode | input | 2 | 0/3 independent stages, 1 decimal chaining, 2 bi-quinary chaining |
| count | output | 4 | {upper stage[2:0], low stage} |

## Verification
The hardest condition to reach from the ports is a carry between stages that lines up with a preset or with a change of link mode. One case is the decimal wrap from 9, which needs a 1-to-0 transition on the low bit together with the upper stage at 4. Another is a count edge that arrives while a preset pair is fully held. Random sequences mix pulses on both inputs with random control patterns, including partial pairs, and with mode switches in the middle of a count. They start from preset states such as nine, so wraps and dropped edges happen often. Directed runs add a full decade in each chained mode and a check of the square-wave duty cycle.

// File: rtl/bqc_pkg.sv
package bqc_pkg;
  typedef enum logic [1:0] {
    LINK_NONE  = 2'd0,
    LINK_DEC   = 2'd1,
    LINK_BIQ   = 2'd2,
    LINK_SPARE = 2'd3
  } link_mode_e;

  localparam int unsigned LOW_MOD  = 2;
  localparam int unsigned HIGH_MOD = 5;
  localparam int unsigned LOW_W    = (LOW_MOD  > 2) ? $clog2(LOW_MOD)  : 1;
  localparam int unsigned HIGH_W   = (HIGH_MOD > 2) ? $clog2(HIGH_MOD) : 1;
  localparam int unsigned CNT_W    = LOW_W + HIGH_W;
  localparam int unsigned NUM_IN   = 2;
endpackage

// File: rtl/bqc_rst_sync.sv
module bqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bqc_fall_detect.sv
module bqc_fall_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic smp_q, old_q;
    logic smp_d, old_d;

    always_comb begin
      smp_d = sig_in[i];
      old_d = smp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q <= 1'b0;
        old_q <= 1'b0;
      end else begin
        smp_q <= smp_d;
        old_q <= old_d;
      end
    end

    assign fall[i] = old_q & ~smp_q;
  end
endmodule

// File: rtl/bqc_mod_counter.sv
module bqc_mod_counter #(
  parameter int unsigned MOD = 5,
  localparam int unsigned W = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         set_top,
  input  logic         adv,
  output logic [W-1:0] value,
  output logic         at_top
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | set_top | adv;
    cnt_d  = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (set_top)        cnt_d = LAST;
    else if (cnt_q == LAST)  cnt_d = '0;
    else                     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign value  = cnt_q;
  assign at_top = (cnt_q == LAST);
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter
  import bqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_a,
  input  logic       cnt_b,
  input  logic       zero_a,
  input  logic       zero_b,
  input  logic       nine_a,
  input  logic       nine_b,
  input  logic [1:0] link_mode,
  output logic [3:0] count
);
  logic              rst_sync_n;
  logic [NUM_IN-1:0] fall_v;
  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic              low_top, high_top;
  logic              force_nine, force_zero, run;
  logic              low_src, high_src, low_adv, high_adv;
  link_mode_e        lmode;

  bqc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bqc_fall_detect #(.N(NUM_IN)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .sig_in({cnt_b, cnt_a}), .fall(fall_v)
  );

  always_comb begin
    lmode      = link_mode_e'(link_mode);
    force_nine = nine_a & nine_b;
    force_zero = zero_a & zero_b & ~force_nine;
    run        = ~(zero_a & zero_b) & ~force_nine;
    // Carries come from stage values, never from the other stage's enable.
    case (lmode)
      LINK_DEC: begin
        low_src  = fall_v[0];
        high_src = fall_v[0] & low_top;
      end
      LINK_BIQ: begin
        low_src  = fall_v[1] & high_top;
        high_src = fall_v[1];
      end
      default: begin
        low_src  = fall_v[0];
        high_src = fall_v[1];
      end
    endcase
    low_adv  = run & low_src;
    high_adv = run & high_src;
  end

  bqc_mod_counter #(.MOD(LOW_MOD)) u_low (
    .clk(clk), .rst_n(rst_sync_n), .clr(force_zero), .set_top(force_nine),
    .adv(low_adv), .value(low_q), .at_top(low_top)
  );

  bqc_mod_counter #(.MOD(HIGH_MOD)) u_high (
    .clk(clk), .rst_n(rst_sync_n), .clr(force_zero), .set_top(force_nine),
    .adv(high_adv), .value(high_q), .at_top(high_top)
  );

  assign count = {high_q, low_q};
endmodule

// File: rtl/bqc_checker.sv
module bqc_checker (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       zero_a,
  input logic       zero_b,
  input logic       nine_a,
  input logic       nine_b,
  input logic [1:0] link_mode,
  input logic [1:0] fall_v,
  input logic [3:0] count
);
  logic nine_on, zero_on;
  assign nine_on = nine_a & nine_b;
  assign zero_on = zero_a & zero_b;

  // R5
  zero_force_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (zero_on && !nine_on) |=> (count == 4'b0000));

  // R6
  nine_force_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nine_on |=> (count == 4'b1001));

  // R3
  high_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    count[3:1] <= 3'd4);

  // R4
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!zero_on && !nine_on && fall_v == 2'b00) |=> $stable(count));

  // R2
  low_toggle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (link_mode != 2'd2 && fall_v[0] && !zero_on && !nine_on)
      |=> (count[0] != $past(count[0])));

  // R8
  dec_ignore_b_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (link_mode == 2'd1 && !fall_v[0] && !zero_on && !nine_on) |=> $stable(count));

  // R9
  biq_ignore_a_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (link_mode == 2'd2 && !fall_v[1] && !zero_on && !nine_on) |=> $stable(count));
endmodule

bind bq_decade_counter bqc_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .zero_a(zero_a), .zero_b(zero_b),
  .nine_a(nine_a), .nine_b(nine_b), .link_mode(link_mode), .fall_v(fall_v),
  .count(count)
);

// File: tb/tb_bq_decade_counter.sv
module tb_bq_decade_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_a, cnt_b, zero_a, zero_b, nine_a, nine_b;
  logic [1:0] link_mode;
  logic [3:0] count;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  logic       m_low;
  logic [2:0] m_high;

  always #2 clk = ~clk;

  bq_decade_counter dut (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .zero_a(zero_a), .zero_b(zero_b), .nine_a(nine_a), .nine_b(nine_b),
    .link_mode(link_mode), .count(count)
  );

  function automatic logic [2:0] inc5(input logic [2:0] v);
    return (v == 3'd4) ? 3'd0 : v + 3'd1;
  endfunction

  function automatic logic [3:0] expected();
    return {m_high, m_low};
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    n_chk++;
    if (count !== exp) begin
      n_fail++;
      $display("FAIL %s: count=%b expected=%b", req, count, exp);
    end
  endtask

  function automatic bit held();
    return (zero_a & zero_b) | (nine_a & nine_b);
  endfunction

  task automatic model_a();
    if (held()) return;
    if (link_mode == 2'd1) begin
      if (m_low) m_high = inc5(m_high);
      m_low = ~m_low;
    end else if (link_mode != 2'd2) begin
      m_low = ~m_low;
    end
  endtask

  task automatic model_b();
    if (held()) return;
    if (link_mode == 2'd2) begin
      if (m_high == 3'd4) m_low = ~m_low;
      m_high = inc5(m_high);
    end else if (link_mode != 2'd1) begin
      m_high = inc5(m_high);
    end
  endtask

  task automatic pulse_a();
    cnt_a = 1'b1;
    repeat (3) @(negedge clk);
    cnt_a = 1'b0;
    repeat (3) @(negedge clk);
    model_a();
  endtask

  task automatic pulse_b();
    cnt_b = 1'b1;
    repeat (3) @(negedge clk);
    cnt_b = 1'b0;
    repeat (3) @(negedge clk);
    model_b();
  endtask

  task automatic apply_ctrl(input logic za, zb, na, nb);
    zero_a = za; zero_b = zb; nine_a = na; nine_b = nb;
    @(negedge clk);
    if (na & nb) begin m_low = 1'b1; m_high = 3'd4; end
    else if (za & zb) begin m_low = 1'b0; m_high = 3'd0; end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: count=%b expected=done", count);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] snap;
    int         highs;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cnt_a = 0; cnt_b = 0; zero_a = 0; zero_b = 0;
    nine_a = 0; nine_b = 0; link_mode = 2'd0;
    m_low = 0; m_high = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 4'b0000);

    // R2: low stage toggles, upper untouched
    for (int i = 0; i < 3; i++) begin pulse_a(); check("R2 toggle", expected()); end
    // R3: full quinary cycle
    for (int i = 0; i < 6; i++) begin pulse_b(); check("R3 quinary", expected()); end
    // R4: a rise and a long high level do nothing
    snap = count;
    cnt_a = 1'b1; cnt_b = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 rise ignored", snap);
    cnt_a = 1'b0; cnt_b = 1'b0;
    repeat (3) @(negedge clk);
    m_low = ~m_low; m_high = inc5(m_high);
    check("R4 fall counts", expected());

    // R5 and R6
    apply_ctrl(1, 1, 0, 1);
    check("R5 zero force", 4'b0000);
    apply_ctrl(1, 1, 1, 1);
    check("R6 nine over zero", 4'b1001);
    apply_ctrl(0, 0, 0, 0);
    // R7: partial pairs still count, full pair drops edges
    apply_ctrl(1, 0, 0, 1);
    pulse_a(); check("R7 partial pair counts", expected());
    apply_ctrl(1, 1, 0, 0);
    pulse_a(); pulse_b();
    apply_ctrl(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R7 edges dropped in hold", 4'b0000);

    // R8: decimal chaining
    link_mode = 2'd1;
    for (int i = 0; i < 12; i++) begin
      pulse_a(); check("R8 decimal step", expected());
    end
    pulse_b(); check("R8 cnt_b ignored", expected());
    apply_ctrl(0, 0, 1, 1); apply_ctrl(0, 0, 0, 0);
    pulse_a(); check("R8 wrap from nine", 4'b0000);

    // R9 / R10: bi-quinary chaining
    link_mode = 2'd2;
    apply_ctrl(1, 1, 0, 0); apply_ctrl(0, 0, 0, 0);
    highs = 0;
    for (int i = 1; i <= 10; i++) begin
      pulse_b(); check("R9 biquinary step", expected());
      if (count[0]) highs++;
      n_chk++;
      if (count[0] !== ((i >= 5 && i <= 9) ? 1'b1 : 1'b0)) begin
        n_fail++;
        $display("FAIL R10 pulse %0d: low=%b expected=%b", i, count[0], (i >= 5 && i <= 9));
      end
    end
    n_chk++;
    if (highs != 5) begin
      n_fail++;
      $display("FAIL R10 duty: highs=%0d expected=5", highs);
    end
    pulse_a(); check("R9 cnt_a ignored", expected());

    // R11: spare code acts as independent
    link_mode = 2'd3;
    pulse_a(); check("R11 spare low", expected());
    pulse_b(); check("R11 spare high", expected());

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      op = $urandom % 9;
      case (op)
        0, 1, 2: begin pulse_a(); check("R2/R8 random A", expected()); end
        3, 4, 5: begin pulse_b(); check("R3/R9 random B", expected()); end
        6: begin
          logic [3:0] c;
          c = 4'($urandom);
          apply_ctrl(c[0], c[1], c[2], c[3]);
          check("R5/R6 random ctrl", expected());
          if ($urandom % 2) pulse_a(); else pulse_b();
          check("R7 random under ctrl", expected());
          apply_ctrl(0, 0, 0, 0);
        end
        7: begin apply_ctrl(0, 0, 1, 1); apply_ctrl(0, 0, 0, 0); check("R6 random nine", 4'b1001); end
        default: begin
          link_mode = 2'($urandom);
          repeat (2) @(negedge clk);
          check("R11 mode switch", expected());
        end
      endcase
    end

    // R1: asynchronous reset mid-count
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    m_low = 0; m_high = 0;
    repeat (4) @(negedge clk);
    check("R1 release", 4'b0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule